// File: doc/BRIEF.md
# Memory-Mapped SPI Flash Window Controller

This block turns ordinary reads and writes on a simple request/acknowledge bus into SPI flash transactions. Each chip select owns an address window and a control register. The register holds an access mode, a command opcode, a four-byte address enable and a chip-select-stop bit. A separate configuration register holds one write-enable bit per chip select. In the three command modes, an access builds its own frame: select the device, send the opcode and the address, move the data bytes, then deselect. In user mode the bus data passes through as raw bytes, and software drives the chip select through the stop bit.

The address is wrapped to the chip select's segment before it is sent. Sticky error outputs report a missing opcode, an address outside the segment and an access that does not fit the mode. The SPI side uses mode 0 with a single data line. It runs at half the system clock and sends the most significant bit first. The bus acknowledge stays low until the whole frame has been sent.

Top module: `spi_flash_window`

## Requirements
- R1: The control register holds the mode in bits 1:0 (0 = read, 1 = fast read, 2 = write, 3 = user), the opcode in bits 23:16, the stop bit in bit 2 and the four-byte enable in bit 8. The configuration register holds the write enable for chip select i in bit i. After reset every control register reads 0x4, so all spi_cs_n are high. After reset the write enables are clear, all error flags are 0 and bus_ack is 0.
- R2: In read mode the opcode byte sent is always 0x03, whatever the opcode field holds, and a zero field raises no error.
- R3: In fast-read or write mode, a zero opcode field sets err_nocmd, which stays set until reset. The frame is still sent, with 0x00 as its opcode.
- R4: In a command-mode frame, the selected spi_cs_n goes low before the first SPI clock and is high again when bus_ack is seen.
- R5: The address follows the opcode with the most significant byte first. It is four bytes (bits 31:24 first) when the four-byte enable is set, and three bytes (bits 23:16, 15:8, 7:0) otherwise.
- R6: The address is masked to the segment of 2^SEG_BITS bytes. If the mask drops any set bit, err_range is set and stays set until reset.
- R7: bus_size 0, 1 and 2 (3 acts as 2) move 1, 2 and 4 data bytes. The first byte on SPI maps to data bits 7:0, the next to bits 15:8, and so on, for both reads and writes. Unused read bytes return 0.
- R8: While a read clocks in its data bytes, MOSI sends 0x00.
- R9: A bus write to a chip select whose write-enable bit is clear is dropped. bus_ack comes one cycle after the request, no SPI clock runs and no error flag changes.
- R10: In write mode a bus write sends the opcode, then the address, then the data bytes, between select and deselect.
- R11: In user mode no opcode or address is sent and the stop bit is left alone. Writes send the data bytes, and reads send 0x00 while they clock data in.
- R12: spi_sclk is clk/2 and idles low. MISO is sampled on the rising edge, and MOSI changes only as SCLK falls, MSB first. An access of B bytes acknowledges 16*B+1 cycles after the request, and bus_ack is a one-cycle pulse.
- R13: A read in write mode, or a write in read or fast-read mode, is acknowledged one cycle after the request. It returns 0, sends nothing and sets err_mode, which stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ctrl_we | input | 1 | Write reg_wdata into control register reg_idx |
| conf_we | input | 1 | Write reg_wdata into the configuration register |
| reg_idx | input | CSW | Chip select addressed by ctrl_we |
| reg_wdata | input | 32 | Register write data |
| bus_req | input | 1 | Access request, held until bus_ack |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_sel | input | CSW | Chip select whose window is accessed |
| bus_addr | input | 32 | Address within the window |
| bus_size | input | 2 | Access size code |
| bus_wdata | input | 32 | Write data |
| bus_ack | output | 1 | One-cycle completion pulse |
| bus_rdata | output | 32 | Read data, valid with bus_ack |
| err_nocmd | output | 1 | Sticky: zero opcode in a command mode |
| err_range | output | 1 | Sticky: address outside the segment |
| err_mode | output | 1 | Sticky: access does not fit the mode |
| spi_sclk | output | 1 | SPI clock |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |
| spi_cs_n | output | NUM_CS | Chip selects, active low |

## Verification
A behavioural flash model records every MOSI byte and returns a known byte sequence on MISO. Each access is compared byte for byte against a frame built from the requirements. The patterns cover:
- a read in read mode with a non-zero opcode field, which shows the fixed opcode;
- fast reads with three- and four-byte addresses, which show the address length;
- an address beyond the segment, which shows the wrap and err_range;
- a write of distinct bytes, which shows the byte order;
- a write to a chip select without write enable, which shows the drop;
- mode-mismatched accesses;
- a user-mode exchange held under one software-controlled select, which shows that MISO bytes continue across accesses with no opcode or address.

Frame lengths, acknowledge latency and SCLK edge counts separate 1-, 2- and 4-byte sizes. On every idle cycle the chip selects are compared with a model of the stop bits.

// File: rtl/spi_flash_window.sv
module spi_flash_window #(
  parameter int NUM_CS   = 2,
  parameter int SEG_BITS = 16,
  localparam int CSW     = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctrl_we,
  input  logic              conf_we,
  input  logic [CSW-1:0]    reg_idx,
  input  logic [31:0]       reg_wdata,
  input  logic              bus_req,
  input  logic              bus_we,
  input  logic [CSW-1:0]    bus_sel,
  input  logic [31:0]       bus_addr,
  input  logic [1:0]        bus_size,
  input  logic [31:0]       bus_wdata,
  output logic              bus_ack,
  output logic [31:0]       bus_rdata,
  output logic              err_nocmd,
  output logic              err_range,
  output logic              err_mode,
  output logic              spi_sclk,
  output logic              spi_mosi,
  input  logic              spi_miso,
  output logic [NUM_CS-1:0] spi_cs_n
);

  localparam logic [1:0]  M_RD = 2'd0, M_WR = 2'd2, M_USR = 2'd3;
  localparam int          B_STOP = 2, B_WIDE = 8;
  localparam logic [31:0] SEG_MASK = (SEG_BITS >= 32) ? 32'hFFFF_FFFF
                                     : ((32'd1 << SEG_BITS) - 32'd1);

  logic [1:0]        mode_q [NUM_CS];
  logic [7:0]        op_q   [NUM_CS];
  logic [NUM_CS-1:0] wide_q, stop_q, wen_q;

  logic              busy, ack_q, auto_q, wr_q, ph;
  logic [2:0]        bc;
  logic [3:0]        bidx, btot, hdr;
  logic [CSW-1:0]    cur;
  logic [71:0]       frame;
  logic [7:0]        rx;
  logic [31:0]       rdata_q;
  logic              e_cmd, e_rng, e_mode;

  logic unused_wd;
  assign unused_wd = ^reg_wdata;

  wire              idx_ok = 32'(reg_idx) < NUM_CS;
  wire              sel_ok = 32'(bus_sel) < NUM_CS;
  wire [CSW-1:0]    sel_c  = sel_ok ? bus_sel : '0;
  wire [1:0]        mode   = mode_q[sel_c];
  wire [7:0]        opf    = op_q[sel_c];
  wire              wide   = wide_q[sel_c];
  wire [31:0]       maddr  = bus_addr & SEG_MASK;
  wire              oor    = (bus_addr & ~SEG_MASK) != 32'd0;
  wire [31:0]       dseq   = bus_we ? {bus_wdata[7:0], bus_wdata[15:8],
                                       bus_wdata[23:16], bus_wdata[31:24]} : 32'd0;
  wire [3:0]        nb     = (bus_size == 2'd0) ? 4'd1 : (bus_size == 2'd1) ? 4'd2 : 4'd4;
  wire [7:0]        opc    = (mode == M_RD) ? 8'h03 : opf;
  wire [3:0]        hlen   = wide ? 4'd5 : 4'd4;

  wire go   = bus_req && !busy && !ack_q;
  wire drop = bus_we && !(sel_ok && wen_q[sel_c]);
  wire usr  = sel_ok && (mode == M_USR);
  wire bad  = !sel_ok || (bus_we != (mode == M_WR));

  wire [1:0] di = 2'(bidx - hdr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_CS; i++) begin
        mode_q[i] <= 2'd0;
        op_q[i]   <= 8'd0;
      end
      wide_q  <= '0;
      stop_q  <= '1;
      wen_q   <= '0;
      busy    <= 1'b0;
      ack_q   <= 1'b0;
      auto_q  <= 1'b0;
      wr_q    <= 1'b0;
      ph      <= 1'b0;
      bc      <= 3'd0;
      bidx    <= 4'd0;
      btot    <= 4'd0;
      hdr     <= 4'd0;
      cur     <= '0;
      frame   <= '0;
      rx      <= 8'd0;
      rdata_q <= 32'd0;
      e_cmd   <= 1'b0;
      e_rng   <= 1'b0;
      e_mode  <= 1'b0;
    end else begin
      ack_q <= 1'b0;
      if (ctrl_we && idx_ok) begin
        mode_q[reg_idx] <= reg_wdata[1:0];
        op_q[reg_idx]   <= reg_wdata[23:16];
        wide_q[reg_idx] <= reg_wdata[B_WIDE];
        stop_q[reg_idx] <= reg_wdata[B_STOP];
      end
      if (conf_we)
        wen_q <= reg_wdata[NUM_CS-1:0];

      if (go) begin
        rdata_q <= 32'd0;
        cur     <= sel_c;
        wr_q    <= bus_we;
        auto_q  <= 1'b0;
        ph      <= 1'b0;
        bc      <= 3'd0;
        bidx    <= 4'd0;
        if (drop) begin
          ack_q <= 1'b1;
        end else if (usr) begin
          busy  <= 1'b1;
          hdr   <= 4'd0;
          btot  <= nb;
          frame <= {dseq, 40'd0};
        end else if (bad) begin
          ack_q  <= 1'b1;
          e_mode <= 1'b1;
        end else begin
          busy   <= 1'b1;
          auto_q <= 1'b1;
          hdr    <= hlen;
          btot   <= hlen + nb;
          frame  <= wide ? {opc, maddr, dseq} : {opc, maddr[23:0], dseq, 8'd0};
          stop_q[sel_c] <= 1'b0;
          if (oor) e_rng <= 1'b1;
          if (mode != M_RD && opf == 8'd0) e_cmd <= 1'b1;
        end
      end else if (busy) begin
        if (!ph) begin
          ph <= 1'b1;
          rx <= {rx[6:0], spi_miso};
        end else begin
          ph    <= 1'b0;
          frame <= {frame[70:0], 1'b0};
          bc    <= bc + 3'd1;
          if (bc == 3'd7) begin
            if (bidx >= hdr && !wr_q)
              rdata_q[{di, 3'b000} +: 8] <= rx;
            bidx <= bidx + 4'd1;
            if (bidx == btot - 4'd1) begin
              busy  <= 1'b0;
              ack_q <= 1'b1;
              if (auto_q) stop_q[cur] <= 1'b1;
            end
          end
        end
      end
    end
  end

  assign bus_ack   = ack_q;
  assign bus_rdata = rdata_q;
  assign err_nocmd = e_cmd;
  assign err_range = e_rng;
  assign err_mode  = e_mode;
  assign spi_sclk  = busy & ph;
  assign spi_mosi  = frame[71];
  assign spi_cs_n  = stop_q;

  p_ack_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
    bus_ack |=> !bus_ack);

  p_mosi_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !spi_sclk |=> $stable(spi_mosi));

  p_cs_low_frame_r4: assert property (@(posedge clk) disable iff (!rst_n)
    busy && auto_q |-> !spi_cs_n[cur]);

  p_cs_release_r4: assert property (@(posedge clk) disable iff (!rst_n)
    bus_ack && auto_q |-> spi_cs_n[cur]);

  p_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    go && drop |=> bus_ack && !busy && !spi_sclk);

  p_illegal_r13: assert property (@(posedge clk) disable iff (!rst_n)
    go && !drop && !usr && bad |=> bus_ack && err_mode && bus_rdata == 32'd0);

  p_err_sticky_r13: assert property (@(posedge clk) disable iff (!rst_n)
    err_mode |=> err_mode);

  p_cmd_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
    err_nocmd |=> err_nocmd);

endmodule

// File: tb/spi_flash_window_tb.sv
module spi_flash_window_tb_top;
  localparam int NUM_CS = 2;
  localparam int SEG_BITS = 16;
  localparam logic [31:0] SMASK = (32'd1 << SEG_BITS) - 32'd1;

  logic clk = 0;
  logic rst_n = 0;
  logic ctrl_we = 0, conf_we = 0;
  logic [0:0] reg_idx = '0;
  logic [31:0] reg_wdata = '0;
  logic bus_req = 0, bus_we = 0;
  logic [0:0] bus_sel = '0;
  logic [31:0] bus_addr = '0, bus_wdata = '0;
  logic [1:0] bus_size = '0;
  logic bus_ack;
  logic [31:0] bus_rdata;
  logic err_nocmd, err_range, err_mode;
  logic spi_sclk, spi_mosi, spi_miso;
  logic [NUM_CS-1:0] spi_cs_n;

  always #5 clk = ~clk;

  spi_flash_window #(.NUM_CS(NUM_CS), .SEG_BITS(SEG_BITS)) dut_i (
    .clk(clk), .rst_n(rst_n), .ctrl_we(ctrl_we), .conf_we(conf_we),
    .reg_idx(reg_idx), .reg_wdata(reg_wdata), .bus_req(bus_req), .bus_we(bus_we),
    .bus_sel(bus_sel), .bus_addr(bus_addr), .bus_size(bus_size), .bus_wdata(bus_wdata),
    .bus_ack(bus_ack), .bus_rdata(bus_rdata), .err_nocmd(err_nocmd),
    .err_range(err_range), .err_mode(err_mode), .spi_sclk(spi_sclk),
    .spi_mosi(spi_mosi), .spi_miso(spi_miso), .spi_cs_n(spi_cs_n));

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  bit in_op = 1;
  logic [NUM_CS-1:0] exp_cs = '1;

  // flash model
  logic [7:0] mq[$];
  logic [7:0] s_in = 0;
  int s_bits = 0, s_bytes = 0, sclk_cnt = 0;
  wire cs_idle = &spi_cs_n;

  function automatic logic [7:0] resp(input int j);
    return 8'(j * 29 + 90);
  endfunction

  always @(posedge spi_sclk) begin
    s_in = {s_in[6:0], spi_mosi};
    s_bits++;
    sclk_cnt++;
    if (s_bits == 8) begin
      mq.push_back(s_in);
      s_bits = 0;
      s_bytes++;
    end
  end

  always @(posedge cs_idle) begin
    s_bits = 0;
    s_bytes = 0;
  end

  logic [7:0] cur_resp;
  always_comb cur_resp = resp(s_bytes);
  assign spi_miso = cur_resp[3'(7 - s_bits)];

  task automatic chk_eq(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !in_op && !done) begin
      chk_eq("R11", "idle chip selects", 64'(spi_cs_n), 64'(exp_cs));
      chk_eq("R12", "idle sclk", 64'(spi_sclk), 64'd0);
    end
  end

  task automatic do_reset();
    in_op = 1;
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    exp_cs = '1;
    @(negedge clk);
    in_op = 0;
  endtask

  task automatic set_ctrl(input int idx, input logic [31:0] v);
    in_op = 1;
    @(negedge clk);
    ctrl_we = 1; reg_idx = 1'(idx); reg_wdata = v;
    @(negedge clk);
    ctrl_we = 0;
    exp_cs[idx] = v[2];
    in_op = 0;
  endtask

  task automatic set_conf(input logic [31:0] v);
    in_op = 1;
    @(negedge clk);
    conf_we = 1; reg_wdata = v;
    @(negedge clk);
    conf_we = 0;
    in_op = 0;
  endtask

  task automatic bus_op(input bit we, input int sel, input logic [31:0] addr, input logic [1:0] size,
                        input logic [31:0] wd, output logic [31:0] rd, output int cyc, output int ns);
    in_op = 1;
    mq.delete();
    sclk_cnt = 0;
    @(negedge clk);
    bus_req = 1; bus_we = we; bus_sel = 1'(sel); bus_addr = addr; bus_size = size; bus_wdata = wd;
    cyc = 0;
    do begin
      @(negedge clk);
      cyc++;
    end while (!bus_ack && cyc < 2000);
    if (!bus_ack) chk_eq("R12", "ack timeout", 64'(cyc), 64'd0);
    rd = bus_rdata;
    ns = sclk_cnt;
    bus_req = 0;
    in_op = 0;
  endtask

  task automatic chk_frame(input string req, input logic [7:0] e[$]);
    chk_eq(req, "frame length", 64'(mq.size()), 64'(e.size()));
    for (int k = 0; k < e.size() && k < mq.size(); k++)
      chk_eq(req, $sformatf("frame byte %0d", k), 64'(mq[k]), 64'(e[k]));
  endtask

  function automatic int nbytes(input logic [1:0] s);
    return (s == 0) ? 1 : (s == 1) ? 2 : 4;
  endfunction

  task automatic build(input logic [7:0] op, input bit wide, input logic [31:0] addr,
                       input logic [1:0] size, input bit we, input logic [31:0] wd,
                       output logic [7:0] e[$]);
    logic [31:0] a;
    a = addr & SMASK;
    e.delete();
    e.push_back(op);
    if (wide) e.push_back(a[31:24]);
    e.push_back(a[23:16]);
    e.push_back(a[15:8]);
    e.push_back(a[7:0]);
    for (int k = 0; k < nbytes(size); k++)
      e.push_back(we ? wd[8*k +: 8] : 8'h00);
  endtask

  function automatic logic [31:0] exp_rd(input int first, input logic [1:0] size);
    logic [31:0] r = 0;
    for (int k = 0; k < nbytes(size); k++) r[8*k +: 8] = resp(first + k);
    return r;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual expired expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    int cyc, ns;
    logic [7:0] e[$];

    do_reset();
    // R1 reset state
    chk_eq("R1", "cs after reset", 64'(spi_cs_n), 64'h3);
    chk_eq("R1", "ack after reset", 64'(bus_ack), 64'd0);
    chk_eq("R1", "errors after reset", 64'({err_nocmd, err_range, err_mode}), 64'd0);

    set_conf(32'h1);
    // R2 read mode, opcode field 0xEB ignored, 3-byte address
    set_ctrl(0, 32'h00EB_0004);
    bus_op(0, 0, 32'h0000_1234, 2'd2, 0, rd, cyc, ns);
    build(8'h03, 0, 32'h1234, 2'd2, 0, 0, e);
    chk_frame("R2 R5 R8", e);
    chk_eq("R7", "read data 4 bytes", 64'(rd), 64'(exp_rd(4, 2'd2)));
    chk_eq("R12", "latency 8 bytes", 64'(cyc), 64'(16*8+1));
    chk_eq("R12", "sclk edges", 64'(ns), 64'(64));
    chk_eq("R4", "cs released", 64'(spi_cs_n[0]), 64'd1);
    chk_eq("R2", "no opcode error", 64'(err_nocmd), 64'd0);

    // R2 read mode with zero opcode field raises nothing
    set_ctrl(0, 32'h0000_0004);
    bus_op(0, 0, 32'h0000_0010, 2'd0, 0, rd, cyc, ns);
    chk_eq("R2", "opcode with zero field", 64'(mq.size() > 0 ? mq[0] : 8'hxx), 64'h03);
    chk_eq("R2", "no error on zero field", 64'(err_nocmd), 64'd0);

    // R5 fast read, four-byte address, 1 byte
    set_ctrl(0, 32'h000B_0105);
    bus_op(0, 0, 32'h0000_ABCD, 2'd0, 0, rd, cyc, ns);
    build(8'h0B, 1, 32'hABCD, 2'd0, 0, 0, e);
    chk_frame("R5", e);
    chk_eq("R7", "read data 1 byte", 64'(rd), 64'(exp_rd(5, 2'd0)));
    chk_eq("R12", "latency 6 bytes", 64'(cyc), 64'(16*6+1));
    chk_eq("R6", "no range error yet", 64'(err_range), 64'd0);

    // R6 out-of-segment address wraps
    set_ctrl(0, 32'h000B_0005);
    bus_op(0, 0, 32'h0005_1234, 2'd1, 0, rd, cyc, ns);
    build(8'h0B, 0, 32'h0005_1234, 2'd1, 0, 0, e);
    chk_frame("R6", e);
    chk_eq("R6", "range error set", 64'(err_range), 64'd1);
    chk_eq("R7", "read data 2 bytes", 64'(rd), 64'(exp_rd(4, 2'd1)));

    // R10 write mode frame, little-endian bytes
    set_ctrl(0, 32'h0002_0006);
    bus_op(1, 0, 32'h0000_0020, 2'd2, 32'hDEAD_BEEF, rd, cyc, ns);
    build(8'h02, 0, 32'h20, 2'd2, 1, 32'hDEAD_BEEF, e);
    chk_frame("R10 R7", e);
    chk_eq("R4", "cs released after write", 64'(spi_cs_n[0]), 64'd1);

    // R9 write to chip select 1 without write enable
    set_ctrl(1, 32'h0002_0006);
    bus_op(1, 1, 32'h0000_0040, 2'd2, 32'h1122_3344, rd, cyc, ns);
    chk_eq("R9", "drop latency", 64'(cyc), 64'd1);
    chk_eq("R9", "drop sends nothing", 64'(ns), 64'd0);
    chk_eq("R9", "drop flags", 64'({err_nocmd, err_mode}), 64'd0);

    // R13 read in write mode
    bus_op(0, 0, 32'h0000_0040, 2'd2, 0, rd, cyc, ns);
    chk_eq("R13", "illegal latency", 64'(cyc), 64'd1);
    chk_eq("R13", "illegal rdata", 64'(rd), 64'd0);
    chk_eq("R13", "illegal sends nothing", 64'(ns), 64'd0);
    chk_eq("R13", "mode error", 64'(err_mode), 64'd1);

    // R3 zero opcode in fast read
    do_reset();
    chk_eq("R1", "errors cleared", 64'({err_nocmd, err_range, err_mode}), 64'd0);
    set_conf(32'h3);
    set_ctrl(0, 32'h0000_0005);
    bus_op(0, 0, 32'h0000_0300, 2'd0, 0, rd, cyc, ns);
    build(8'h00, 0, 32'h300, 2'd0, 0, 0, e);
    chk_frame("R3", e);
    chk_eq("R3", "opcode error", 64'(err_nocmd), 64'd1);

    // R13 write in read mode
    set_ctrl(0, 32'h0003_0004);
    bus_op(1, 0, 32'h0000_0300, 2'd0, 32'h55, rd, cyc, ns);
    chk_eq("R13", "write in read mode sends nothing", 64'(ns), 64'd0);
    chk_eq("R13", "write in read mode flag", 64'(err_mode), 64'd1);

    // R11 user mode, software select on chip select 1
    set_ctrl(1, 32'h0000_0003);
    chk_eq("R11", "software select low", 64'(spi_cs_n[1]), 64'd0);
    bus_op(1, 1, 32'h0000_0000, 2'd1, 32'h0000_5A9F, rd, cyc, ns);
    e.delete(); e.push_back(8'h9F); e.push_back(8'h5A);
    chk_frame("R11", e);
    chk_eq("R11", "select held after write", 64'(spi_cs_n[1]), 64'd0);
    bus_op(0, 1, 32'h0000_0000, 2'd2, 0, rd, cyc, ns);
    e.delete(); for (int k = 0; k < 4; k++) e.push_back(8'h00);
    chk_frame("R11 R8", e);
    chk_eq("R11", "user read data", 64'(rd), 64'(exp_rd(2, 2'd2)));
    chk_eq("R12", "user latency", 64'(cyc), 64'(16*4+1));
    set_ctrl(1, 32'h0000_0007);
    chk_eq("R11", "software release", 64'(spi_cs_n[1]), 64'd1);

    repeat (4) @(negedge clk);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule